// File: doc/BRIEF.md
# Flash read-response multiplexer

This block forms the data returned to the host for every read of a parallel flash model. A separate command sequencer reports which state it is in. The block then picks one of four answers: array bytes packed for a 1-, 2- or 4-byte access, identification words while in autoselect, a status byte whose bit 6 flips on each poll while a program or erase runs, or bytes from a small query table.

The block also keeps a status byte. A program load, an erase start and an operation-complete event update it. It also tracks a lazy ROM-style read flag. Any write clears the flag. It is set again once enough consecutive plain reads arrive while no command is in progress. Read data is registered, so it appears one cycle after the read strobe and holds until the next read.

Top module: `frm_read_mux`

## Requirements
- R1: After reset, `rdata_o` is 0, `rom_mode_o` is 1 and the internal status byte is 0x00.
- R2: `rdata_o` takes its new value on the clock edge that samples `rd_i` high, which is one cycle of latency, and keeps its value in cycles without a read.
- R3: With `mode_i` = 0 (idle) or any code not listed below, a read returns array data. Byte k of `arr_data_i` (bits 8k+7:8k) is the byte at address+k. `size_i` 0/1/2 selects 1/2/4 bytes. Little-endian (`big_endian_i`=0) places address+0 in the least significant byte. Big-endian places it in the most significant byte of the access. Unused upper bits are zero.
- R4: The word offset is `addr_i` shifted right by 0, 1 or 2 for a device width of 1, 2 or 4 bytes. The default width is 2 bytes, so the shift is 1.
- R5: With `mode_i` = 2 (autoselect), offsets 0 and 1 return the primary ID words `ID0` and `ID1`, and offset 2 returns 0.
- R6: In autoselect, offsets 0x0E and 0x0F return `ID2` and `ID3` unless that word is all ones, in which case array data is returned. Every other offset returns array data.
- R7: With `mode_i` = 3 (busy), a read returns the current status byte, zero-extended, and bit 6 of the status is inverted afterwards.
- R8: `prog_i` loads the status with {~`prog_bit7_i`, 7'h7F}, and `erase_i` loads 0x00. Either load takes priority over the toggles. `done_i` inverts status bit 7.
- R9: With `mode_i` = 4 (query), an offset above `QRY_LEN` (default 0x52) returns 0. Offsets 0x10..0x14 return 'Q','R','Y',0x02,0x00, and offset 0x15 returns 0x31.
- R10: With `mode_i` = 1 (command sequence in progress), reads return array data and are not counted toward the ROM-mode threshold.
- R11: A write clears `rom_mode_o` and the read count on the next edge. A write in the same cycle as a read takes precedence over counting. The 43rd consecutive idle read (`ROM_THRESH`+1) that follows sets `rom_mode_o` on its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Host read strobe, one cycle per access |
| wr_i | input | 1 | Host write seen by the flash model |
| addr_i | input | 8 | Low byte of the host byte address |
| size_i | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| big_endian_i | input | 1 | Byte order for multi-byte array reads |
| mode_i | input | 3 | Sequencer state: 0 idle, 1 sequence, 2 autoselect, 3 busy, 4 query |
| arr_data_i | input | 32 | Array bytes at address+0..+3 |
| prog_i | input | 1 | Program accepted, load status |
| prog_bit7_i | input | 1 | Bit 7 of the programmed data |
| erase_i | input | 1 | Erase started, clear status |
| done_i | input | 1 | Operation complete, flip status bit 7 |
| rdata_o | output | 32 | Registered read data |
| rom_mode_o | output | 1 | ROM-style read mode flag |

## Verification
The assertions take for granted that `mode_i` is stable during the cycle of a read. They also assume the status-load strobes never coincide with a status poll whose toggle is being checked, and `stat_tgl_chk` is written to exclude those cycles. The stimulus drives every input on the falling edge and issues at most one operation per cycle. It never sets `erase_i` and `prog_i` together and never uses size code 3. The ROM-threshold runs are built from exact counts of idle reads, with sequence-mode reads and writes placed between them.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum logic [2:0] {
    RM_IDLE    = 3'd0,
    RM_SEQ     = 3'd1,
    RM_AUTOSEL = 3'd2,
    RM_STATUS  = 3'd3,
    RM_QUERY   = 3'd4
  } rd_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int unsigned DATA_BYTES = 4;
  localparam int unsigned DATA_W     = 8 * DATA_BYTES;
endpackage

// File: rtl/frm_lane_pack.sv
module frm_lane_pack
  import frm_pkg::*;
(
  input  logic [DATA_W-1:0] arr_i,
  input  logic [1:0]        size_i,
  input  logic              be_i,
  output logic [DATA_W-1:0] data_o
);
  logic [7:0] lane [DATA_BYTES];

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_lane
    assign lane[k] = arr_i[8*k +: 8];
  end

  always_comb begin
    data_o = '0;
    unique case (acc_size_e'(size_i))
      SZ_HALF: data_o[15:0] = be_i ? {lane[0], lane[1]} : {lane[1], lane[0]};
      SZ_WORD: data_o = be_i ? {lane[0], lane[1], lane[2], lane[3]} : arr_i;
      default: data_o[7:0] = lane[0];
    endcase
  end
endmodule

// File: rtl/frm_query_rom.sv
module frm_query_rom #(
  parameter logic [7:0] QRY_LEN = 8'h52
) (
  input  logic [7:0] off_i,
  output logic [7:0] byte_o
);
  logic [7:0] tbl;

  always_comb begin
    unique case (off_i)
      8'h10:   tbl = 8'h51;  // 'Q'
      8'h11:   tbl = 8'h52;  // 'R'
      8'h12:   tbl = 8'h59;  // 'Y'
      8'h13:   tbl = 8'h02;  // command set, low
      8'h14:   tbl = 8'h00;  // command set, high
      8'h15:   tbl = 8'h31;  // extended table pointer
      default: tbl = 8'h00;
    endcase
  end

  assign byte_o = (off_i > QRY_LEN) ? 8'h00 : tbl;
endmodule

// File: rtl/frm_rom_track.sv
module frm_rom_track #(
  parameter int unsigned ROM_THRESH = 42
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic idle_rd_i,
  output logic rom_o
);
  localparam int unsigned CNT_W = $clog2(ROM_THRESH + 2);

  logic [CNT_W-1:0] cnt_q;
  logic             rom_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rom_q <= 1'b1;
    end else if (wr_i) begin
      cnt_q <= '0;
      rom_q <= 1'b0;
    end else if (idle_rd_i && !rom_q) begin
      if (cnt_q == CNT_W'(ROM_THRESH)) rom_q <= 1'b1;
      else                             cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rom_o = rom_q;
endmodule

// File: rtl/frm_read_mux.sv
module frm_read_mux
  import frm_pkg::*;
#(
  parameter int unsigned DEV_BYTES  = 2,
  parameter int unsigned ID_W       = 16,
  parameter logic [ID_W-1:0] ID0    = 16'h0001,
  parameter logic [ID_W-1:0] ID1    = 16'h227E,
  parameter logic [ID_W-1:0] ID2    = 16'h2210,
  parameter logic [ID_W-1:0] ID3    = 16'hFFFF,
  parameter logic [7:0] QRY_LEN     = 8'h52,
  parameter int unsigned ROM_THRESH = 42
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [7:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic        big_endian_i,
  input  logic [2:0]  mode_i,
  input  logic [31:0] arr_data_i,
  input  logic        prog_i,
  input  logic        prog_bit7_i,
  input  logic        erase_i,
  input  logic        done_i,
  output logic [31:0] rdata_o,
  output logic        rom_mode_o
);
  localparam int unsigned OFF_SH = (DEV_BYTES >= 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;
  localparam logic [ID_W-1:0] ID_ABSENT = '1;

  rd_mode_e          mode;
  logic [7:0]        boff;
  logic [DATA_W-1:0] arr_word, resp, rdata_q;
  logic [7:0]        qry_byte, status_q;

  assign mode = rd_mode_e'(mode_i);
  assign boff = addr_i >> OFF_SH;

  frm_lane_pack i_pack (
    .arr_i  (arr_data_i),
    .size_i (size_i),
    .be_i   (big_endian_i),
    .data_o (arr_word)
  );

  frm_query_rom #(.QRY_LEN(QRY_LEN)) i_qry (
    .off_i  (boff),
    .byte_o (qry_byte)
  );

  frm_rom_track #(.ROM_THRESH(ROM_THRESH)) i_rom (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .idle_rd_i (rd_i && (mode == RM_IDLE)),
    .rom_o     (rom_mode_o)
  );

  always_comb begin
    resp = arr_word;
    unique case (mode)
      RM_AUTOSEL: begin
        unique case (boff)
          8'h00: resp = DATA_W'(ID0);
          8'h01: resp = DATA_W'(ID1);
          8'h02: resp = '0;
          8'h0E: if (ID2 != ID_ABSENT) resp = DATA_W'(ID2);
          8'h0F: if (ID3 != ID_ABSENT) resp = DATA_W'(ID3);
          default: ;
        endcase
      end
      RM_STATUS: resp = DATA_W'(status_q);
      RM_QUERY:  resp = DATA_W'(qry_byte);
      default: ;
    endcase
  end

  // status: loads win; poll and completion toggles combine
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 8'h00;
    end else if (erase_i) begin
      status_q <= 8'h00;
    end else if (prog_i) begin
      status_q <= {~prog_bit7_i, 7'h7F};
    end else begin
      status_q <= status_q ^ {done_i, (rd_i && mode == RM_STATUS), 6'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= resp;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/frm_read_mux_chk.sv
module frm_read_mux_chk #(
  parameter int unsigned DEV_BYTES = 2,
  parameter logic [7:0] QRY_LEN    = 8'h52
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_i,
  input logic        wr_i,
  input logic [7:0]  addr_i,
  input logic [1:0]  size_i,
  input logic [2:0]  mode_i,
  input logic        prog_i,
  input logic        erase_i,
  input logic        done_i,
  input logic [31:0] rdata_o,
  input logic        rom_mode_o,
  input logic [7:0]  status_q
);
  localparam int unsigned SH = (DEV_BYTES >= 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;
  logic [7:0] woff;
  assign woff = addr_i >> SH;

  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // R11
  wr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !rom_mode_o);

  // R11
  rom_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rom_mode_o) |-> $past(rd_i && !wr_i && mode_i == 3'd0));

  // R8
  erase_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> status_q == 8'h00);

  // R7
  stat_tgl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && mode_i == 3'd3 && !erase_i && !prog_i && !done_i)
      |=> (status_q[6] != $past(status_q[6])) && (rdata_o[31:8] == 24'h0));

  // R3
  byte_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && mode_i == 3'd0 && size_i == 2'd0) |=> rdata_o[31:8] == 24'h0);

  // R9
  qry_past_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && mode_i == 3'd4 && woff > QRY_LEN) |=> rdata_o == 32'h0);
endmodule

bind frm_read_mux frm_read_mux_chk #(.DEV_BYTES(DEV_BYTES), .QRY_LEN(QRY_LEN)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .size_i     (size_i),
  .mode_i     (mode_i),
  .prog_i     (prog_i),
  .erase_i    (erase_i),
  .done_i     (done_i),
  .rdata_o    (rdata_o),
  .rom_mode_o (rom_mode_o),
  .status_q   (status_q)
);

// File: tb/test_frm_read_mux.sv
module test_frm_read_mux;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_i = 0, wr_i = 0, big_endian_i = 0;
  logic [7:0]  addr_i = 0;
  logic [1:0]  size_i = 0;
  logic [2:0]  mode_i = 0;
  logic [31:0] arr_data_i = 0;
  logic        prog_i = 0, prog_bit7_i = 0, erase_i = 0, done_i = 0;
  logic [31:0] rdata_o;
  logic        rom_mode_o;

  int    n_chk = 0, n_err = 0;
  string tag = "R1";
  bit    finished = 0;

  // reference state
  logic [31:0] m_rdata;
  logic [7:0]  m_stat;
  bit          m_rom;
  int          m_cnt;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  frm_read_mux i_frm_read_mux (.*);

  function automatic logic [7:0] mem_byte(int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  function automatic logic [31:0] arr_of(logic [7:0] a);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = mem_byte(int'(a) + k);
    return w;
  endfunction

  function automatic logic [31:0] pack_ref(logic [31:0] w, int sz, bit be);
    int n = 1 << sz;
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) begin
      if (be) v = (v << 8) | 32'(w[8*i +: 8]);
      else    v = v | (32'(w[8*i +: 8]) << (8*i));
    end
    return v;
  endfunction

  function automatic logic [7:0] qry_ref(int off);
    if (off > 'h52) return 8'h00;
    case (off)
      'h10: return "Q";
      'h11: return "R";
      'h12: return "Y";
      'h13: return 8'h02;
      'h15: return 8'h31;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] resp_ref();
    int off = int'(addr_i) / 2;
    logic [31:0] arr = pack_ref(arr_data_i, int'(size_i), big_endian_i);
    case (mode_i)
      3'd2: begin
        if (off == 0) return 32'h0001;
        if (off == 1) return 32'h227E;
        if (off == 2) return 32'h0;
        if (off == 'h0E) return 32'h2210;   // ID2 present
        return arr;                          // 0x0F: ID3 all ones
      end
      3'd3: return {24'h0, m_stat};
      3'd4: return {24'h0, qry_ref(off)};
      default: return arr;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rdata = 0; m_stat = 0; m_rom = 1; m_cnt = 0;
    end else begin
      if (rd_i) m_rdata = resp_ref();
      if (erase_i)     m_stat = 8'h00;
      else if (prog_i) m_stat = {~prog_bit7_i, 7'h7F};
      else begin
        if (done_i) m_stat ^= 8'h80;
        if (rd_i && mode_i == 3'd3) m_stat ^= 8'h40;
      end
      if (wr_i) begin
        m_rom = 0; m_cnt = 0;
      end else if (rd_i && mode_i == 3'd0 && !m_rom) begin
        m_cnt++;
        if (m_cnt > 42) m_rom = 1;
      end
    end
  end

  always @(posedge clk_i) begin
    #(CLK_PERIOD/4);
    if (rst_ni && !finished) begin
      n_chk++;
      if (rdata_o !== m_rdata || rom_mode_o !== m_rom) begin
        n_err++;
        $display("FAIL %s rdata=%h exp=%h rom=%b exp=%b", tag, rdata_o, m_rdata, rom_mode_o, m_rom);
      end
    end
  end

  task automatic drv(bit rd, bit wr, logic [7:0] a, int sz, bit be, int md,
                     bit pg = 0, bit b7 = 0, bit er = 0, bit dn = 0);
    @(negedge clk_i);
    rd_i = rd; wr_i = wr; addr_i = a; size_i = 2'(sz); big_endian_i = be;
    mode_i = 3'(md); arr_data_i = arr_of(a);
    prog_i = pg; prog_bit7_i = b7; erase_i = er; done_i = dn;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drv(0, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic rd(logic [7:0] a, int md, int sz = 0, bit be = 0);
    drv(1, 0, a, sz, be, md);
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    idle(2);                                 // R1 reset values

    tag = "R11"; drv(0, 1, 8'h00, 0, 0, 0); idle(1);

    tag = "R3";
    for (int sz = 0; sz < 3; sz++)
      for (int be = 0; be < 2; be++) rd(8'h10 + 8'(sz * 17), 0, sz, be[0]);
    tag = "R2"; idle(3);

    tag = "R11";
    drv(0, 1, 8'h00, 0, 0, 0);
    for (int i = 0; i < 42; i++) rd(8'(i * 3), 0, i % 3, i[0]);
    idle(2);                                 // still ROM off after 42
    rd(8'h40, 0); idle(2);                   // 43rd sets ROM mode
    drv(1, 1, 8'h44, 0, 0, 0); idle(1);      // R11 write beats read

    tag = "R10";
    for (int i = 0; i < 50; i++) rd(8'(i), 1, 2, 1);
    rd(8'h05, 0, 1, 0); idle(1);

    tag = "R5";
    rd(8'h00, 2); rd(8'h02, 2); rd(8'h04, 2);
    tag = "R4"; rd(8'h03, 2); rd(8'h1D, 2);
    tag = "R6"; rd(8'h1C, 2); rd(8'h1E, 2, 2, 1); rd(8'h08, 2, 1, 0);
    idle(1);

    tag = "R8"; drv(0, 0, 8'h00, 0, 0, 0, 1, 1); idle(1);
    tag = "R7"; rd(8'h00, 3); rd(8'h00, 3); rd(8'h00, 3);
    tag = "R8"; drv(0, 0, 8'h00, 0, 0, 0, 1, 0); rd(8'h00, 3);
    drv(0, 0, 8'h00, 0, 0, 0, 0, 0, 1); rd(8'h00, 3); rd(8'h00, 3);
    drv(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, 1); rd(8'h00, 3);
    drv(1, 0, 8'h00, 0, 0, 3, 0, 0, 0, 1); rd(8'h00, 3);
    idle(1);

    tag = "R9";
    for (int i = 0; i < 6; i++) rd(8'h20 + 8'(2 * i), 4);
    rd(8'hA4, 4); rd(8'hA8, 4); rd(8'hFE, 4); rd(8'h00, 4);
    tag = "R2"; idle(3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_err++;
      $display("FAIL watchdog rdata=%h exp=%h", rdata_o, m_rdata);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule